// File: doc/BRIEF.md
# NVRAM Header Checksum Engine

This block computes a 16-bit nibble-folding checksum over a range of bytes held in a byte-wide memory. A single-cycle start pulse hands it a base address, a byte count, an optional write-back enable and a destination address. The engine then reads the range one byte per cycle through a synchronous read port whose data arrives one cycle after the request. It folds the bytes into the checksum, optionally stores the result as two bytes, and raises a done flag that stays up until the next start.

The bytes are taken as 16-bit words, with the byte at the lower address as the high half. A new word begins at every byte offset, so neighbouring words share a byte. An even count E (the count with bit 0 cleared) therefore gives E word updates. An odd final byte is folded as one more word with that byte in the upper half. A typical use is sealing a boot parameter header: range 0x00 with count 0xF8, result stored at 0xFC.

Top module: `nvck_engine`

## Requirements
- R1: After reset, busy, done, memRe and memWe are all 0.
- R2: The checksum accumulator starts at 0xFFFF. A byte count of 0 yields result 0xFFFF and issues no memory reads.
- R3: Each word w updates the checksum prev to (prev>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits. Here a = (prev^w)[3:0] and b = (prev^w)[7:4] ^ a.
- R4: Let E be byteCount with bit 0 cleared. Word i, for i = 0..E-1, is {mem[base+i], mem[base+i+1]}. Words are processed in increasing i, and addresses wrap modulo the address space.
- R5: When byteCount is odd, one final update uses the word {mem[base+E], 8'h00}.
- R6: Counted from the clock edge that samples start, done rises N edges later, where N = 3·E + 2·(byteCount odd) + 2·writeBack. busy is 1 for exactly those N cycles, busy and done are never both 1, and memRe and memWe are never both 1.
- R7: With writeBack=1, result[15:8] is written at dstAddr and result[7:0] at dstAddr+1 before done rises. With writeBack=0 no memory write occurs.
- R8: done and result hold until the next start. A start pulse while busy is ignored: the run's result and timing are unchanged. A start while done begins a new run.
- R9: The engine reads 2·E + (byteCount odd) bytes per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when not busy |
| startAddr | input | AW | First byte address of the range |
| byteCount | input | CW | Number of bytes to cover |
| writeBack | input | 1 | Store the result at dstAddr when 1 |
| dstAddr | input | AW | Address of the result's high byte |
| memRe | output | 1 | Memory read request |
| memAddr | output | AW | Memory address for read or write |
| memRdata | input | 8 | Read data, valid the cycle after memRe |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid, held until next start |
| result | output | 16 | Checksum value |

## Verification
Each result is due a fixed number of edges after the edge that samples start: three per word, two for a trailing byte and two for write-back (R6). The bench's model counts down that figure and compares busy and done at every falling edge. The result, the read count and the two stored bytes are compared only once the model's count has reached zero. A start pulse injected part way through a run must leave that countdown and the final result untouched.

// File: rtl/nvck_pkg.sv
package nvck_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_HI, ST_RD_LO, ST_UPDATE, ST_TAIL,
    ST_TAIL_FOLD, ST_WRITE_HI, ST_WRITE_LO, ST_DONE
  } nvckState_e;

  typedef struct packed {
    logic init;      // latch parameters, reset accumulator
    logic rdHi;      // request high byte of word
    logic rdLo;      // request low byte, capture high byte
    logic fold;      // fold full word, advance index
    logic rdTail;    // request odd trailing byte
    logic foldTail;  // fold trailing byte in upper half
    logic wrHi;      // store result high byte
    logic wrLo;      // store result low byte
  } nvckCtl_t;

  function automatic logic [15:0] foldStep(input logic [15:0] prev, input logic [15:0] w);
    logic [15:0] d, a, b;
    d = prev ^ w;
    a = {12'h000, d[3:0]};
    b = {12'h000, d[7:4] ^ d[3:0]};
    return (prev >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

endpackage

// File: rtl/nvck_ctrl.sv
module nvck_ctrl
  import nvck_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     startEven,
  input  logic     startOdd,
  input  logic     startWb,
  input  logic     moreWords,
  input  logic     tailPending,
  input  logic     wbEn,
  output nvckCtl_t ctl,
  output logic     busy,
  output logic     done
);

  nvckState_e state, nextState;
  logic accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          if (startEven)     nextState = ST_RD_HI;
          else if (startOdd) nextState = ST_TAIL;
          else if (startWb)  nextState = ST_WRITE_HI;
          else               nextState = ST_DONE;
        end
      end
      ST_RD_HI:  nextState = ST_RD_LO;
      ST_RD_LO:  nextState = ST_UPDATE;
      ST_UPDATE: begin
        if (moreWords)        nextState = ST_RD_HI;
        else if (tailPending) nextState = ST_TAIL;
        else if (wbEn)        nextState = ST_WRITE_HI;
        else                  nextState = ST_DONE;
      end
      ST_TAIL:      nextState = ST_TAIL_FOLD;
      ST_TAIL_FOLD: nextState = wbEn ? ST_WRITE_HI : ST_DONE;
      ST_WRITE_HI:  nextState = ST_WRITE_LO;
      ST_WRITE_LO:  nextState = ST_DONE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl          = '0;
    ctl.init     = accept;
    ctl.rdHi     = (state == ST_RD_HI);
    ctl.rdLo     = (state == ST_RD_LO);
    ctl.fold     = (state == ST_UPDATE);
    ctl.rdTail   = (state == ST_TAIL);
    ctl.foldTail = (state == ST_TAIL_FOLD);
    ctl.wrHi     = (state == ST_WRITE_HI);
    ctl.wrLo     = (state == ST_WRITE_LO);
  end

  assign busy = !(state == ST_IDLE || state == ST_DONE);
  assign done = (state == ST_DONE);

  // R6: busy and done exclusive
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8: done holds without a new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R8: a start while busy does not end the run early
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !ctl.wrLo && !(ctl.fold && !moreWords && !tailPending && !wbEn)
      && !(ctl.foldTail && !wbEn)) |=> busy);

endmodule

// File: rtl/nvck_dpath.sv
module nvck_dpath
  import nvck_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  nvckCtl_t      ctl,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] byteCount,
  input  logic          writeBack,
  input  logic [AW-1:0] dstAddr,
  input  logic [7:0]    memRdata,
  output logic          memRe,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [7:0]    memWdata,
  output logic [15:0]   result,
  output logic          startEven,
  output logic          startOdd,
  output logic          moreWords,
  output logic          tailPending,
  output logic          wbEn
);

  localparam int IW = CW + 1;
  localparam logic [15:0] SEED = 16'hFFFF;

  logic [AW-1:0] baseQ, dstQ;
  logic [CW-1:0] evenQ, idxQ;
  logic          oddQ, wbQ;
  logic [7:0]    hiByte;
  logic [15:0]   acc;

  assign startEven = (byteCount[CW-1:1] != '0);
  assign startOdd  = byteCount[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      dstQ   <= '0;
      evenQ  <= '0;
      oddQ   <= 1'b0;
      wbQ    <= 1'b0;
      idxQ   <= '0;
      hiByte <= '0;
      acc    <= SEED;
    end else begin
      if (ctl.init) begin
        baseQ <= startAddr;
        dstQ  <= dstAddr;
        evenQ <= {byteCount[CW-1:1], 1'b0};
        oddQ  <= byteCount[0];
        wbQ   <= writeBack;
        idxQ  <= '0;
        acc   <= SEED;
      end
      if (ctl.rdLo) hiByte <= memRdata;
      if (ctl.fold) begin
        acc  <= foldStep(acc, {hiByte, memRdata});
        idxQ <= idxQ + 1'b1;
      end
      if (ctl.foldTail) acc <= foldStep(acc, {memRdata, 8'h00});
    end
  end

  assign moreWords   = ({1'b0, idxQ} + IW'(1)) < {1'b0, evenQ};
  assign tailPending = oddQ;
  assign wbEn        = wbQ;

  always_comb begin
    memAddr = baseQ + AW'(idxQ);
    if (ctl.rdLo)   memAddr = baseQ + AW'(idxQ) + AW'(1);
    if (ctl.rdTail) memAddr = baseQ + AW'(evenQ);
    if (ctl.wrHi)   memAddr = dstQ;
    if (ctl.wrLo)   memAddr = dstQ + AW'(1);
  end

  assign memRe    = ctl.rdHi | ctl.rdLo | ctl.rdTail;
  assign memWe    = ctl.wrHi | ctl.wrLo;
  assign memWdata = ctl.wrHi ? acc[15:8] : acc[7:0];
  assign result   = acc;

  // R2: accumulator seeded on acceptance
  p_acc_seed_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.init |=> (acc == 16'hFFFF));

  // R6: one port operation per cycle
  p_single_access_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R7: writes only in a write-back run
  p_write_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> wbQ);

  // R8: result stable while idle between runs
  p_result_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.init && !ctl.fold && !ctl.foldTail) |=> $stable(result));

endmodule

// File: rtl/nvck_engine.sv
module nvck_engine
  import nvck_pkg::*;
#(
  parameter int AW = 13,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] startAddr,
  input  logic [CW-1:0] byteCount,
  input  logic          writeBack,
  input  logic [AW-1:0] dstAddr,
  output logic          memRe,
  output logic [AW-1:0] memAddr,
  input  logic [7:0]    memRdata,
  output logic          memWe,
  output logic [7:0]    memWdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   result
);

  nvckCtl_t ctl;
  logic startEven, startOdd, moreWords, tailPending, wbEn;

  nvck_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .startEven(startEven), .startOdd(startOdd), .startWb(writeBack),
    .moreWords(moreWords), .tailPending(tailPending), .wbEn(wbEn),
    .ctl(ctl), .busy(busy), .done(done)
  );

  nvck_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .startAddr(startAddr), .byteCount(byteCount), .writeBack(writeBack),
    .dstAddr(dstAddr), .memRdata(memRdata),
    .memRe(memRe), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .result(result), .startEven(startEven), .startOdd(startOdd),
    .moreWords(moreWords), .tailPending(tailPending), .wbEn(wbEn)
  );

  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !memRe && !memWe));

endmodule

// File: tb/nvck_engine_tb.sv
module nvck_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [CW-1:0] byteCount = '0;
  logic          writeBack = 1'b0;
  logic [AW-1:0] dstAddr = '0;
  logic          memRe, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memRdata = '0;
  logic [7:0]    memWdata;
  logic          busy, done;
  logic [15:0]   result;

  int checks = 0;
  int fails = 0;
  int reads = 0;
  bit finished = 0;
  logic [7:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvck_engine #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteCount(byteCount), .writeBack(writeBack), .dstAddr(dstAddr),
    .memRe(memRe), .memAddr(memAddr), .memRdata(memRdata),
    .memWe(memWe), .memWdata(memWdata), .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    if (memRe) begin
      memRdata <= mem[memAddr];
      reads <= reads + 1;
    end
    if (memWe) mem[memAddr] <= memWdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stepRef(input int prev, input int w);
    int d, a, b, r;
    d = prev ^ w;
    a = d & 15;
    b = ((d >> 4) & 15) ^ a;
    r = (prev >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
    return r & 'hFFFF;
  endfunction

  function automatic int sumRef(input int base, input int cnt);
    int crc = 'hFFFF;
    int e = cnt & ~1;
    for (int i = 0; i < e; i++)
      crc = stepRef(crc, (int'(mem[(base + i) & 255]) << 8) | int'(mem[(base + i + 1) & 255]));
    if (cnt & 1) crc = stepRef(crc, int'(mem[(base + e) & 255]) << 8);
    return crc;
  endfunction

  task automatic runOnce(input string tag, input int base, input int cnt, input bit wb,
                         input int dst, input int injectAt);
    int exp, n, e, k, old0, old1;
    exp  = sumRef(base, cnt);
    e    = cnt & ~1;
    n    = 3 * e + 2 * (cnt & 1) + 2 * int'(wb);
    old0 = mem[dst & 255];
    old1 = mem[(dst + 1) & 255];
    @(negedge clk);
    startAddr = AW'(base); byteCount = CW'(cnt); writeBack = wb; dstAddr = AW'(dst);
    start = 1'b1;
    reads = 0;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    forever begin
      check(busy == (k < n), "R6 busy", busy, k < n);
      check(done == (k >= n), "R6 done", done, k >= n);
      if (k >= n) break;
      if (k == injectAt) begin
        start = 1'b1; byteCount = '0; writeBack = ~wb; startAddr = AW'(base + 7);  // R8 pulse while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(result == 16'(exp), tag, result, exp);
    check(reads == 2 * e + (cnt & 1), "R9 read count", reads, 2 * e + (cnt & 1));
    if (wb) begin
      check(mem[dst & 255] == 8'(exp >> 8), "R7 high byte", mem[dst & 255], exp >> 8);
      check(mem[(dst + 1) & 255] == 8'(exp), "R7 low byte", mem[(dst + 1) & 255], exp & 255);
    end else begin
      check(mem[dst & 255] == 8'(old0) && mem[(dst + 1) & 255] == 8'(old1),
            "R7 no write", {mem[dst & 255], mem[(dst + 1) & 255]}, (old0 << 8) | old1);
    end
    repeat (3) begin
      @(negedge clk);
      check(done && result == 16'(exp), "R8 hold", {done, result}, (1 << 16) | exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRe && !memWe, "R1 reset", {busy, done, memRe, memWe}, 0);
    rstN = 1'b1;
    runOnce("R2 zero count", 16, 0, 1'b0, 200, -1);
    runOnce("R2 zero count wb", 16, 0, 1'b1, 200, -1);
    runOnce("R5 single byte", 33, 1, 1'b0, 210, -1);
    runOnce("R3 one pair", 40, 2, 1'b1, 212, -1);
    runOnce("R5 odd tail", 50, 5, 1'b1, 214, -1);
    runOnce("R4 wrap range", 250, 10, 1'b0, 216, -1);
    runOnce("R8 busy start", 60, 9, 1'b1, 218, 4);
    runOnce("R4 header", 0, 248, 1'b1, 252, -1);
    runOnce("R8 restart", 100, 7, 1'b0, 220, -1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule